// File: doc/BRIEF.md
# Dual-Side Status Mailbox

This block is a small handshake point between a host processor and a DSP. They share a single 16-bit status word. Either side can overwrite it. A two-bit flag register sits beside the word and records who wrote it most recently. Bit 1 marks a host write and bit 0 marks a DSP write.

Each side has a read that returns the flag register and also clears the flag that belongs to the reader. A processor can therefore poll the flags, see that the other side has posted a new word, and fetch it.

The host reaches the block through a small offset-decoded register window. The DSP reaches it through two select values: a data port and a flag port. A DSP write to the flag port loads the two flags directly. Read data on both sides is registered: it appears one cycle after the read strobe and stays until the next read on that side.

Top module: `smbx_top`

## Requirements
- R1: Reset clears the data word, both flags, both read-data outputs and the error output.
- R2: A host write to offset 0 or offset 1 stores `host_wdata` as the data word and sets flag bit 1.
- R3: A host read of offset 0 or offset 1 returns the data word on `host_rdata` in the cycle after the strobe.
- R4: A host read of offset 2 returns the flags in `host_rdata[1:0]`, with the upper bits zero, and then clears flag bit 0.
- R5: A DSP write with `dsp_sel`=1 stores `dsp_wdata` as the data word and sets flag bit 0. A DSP read with `dsp_sel`=1 returns the data word on `dsp_rdata`.
- R6: A DSP read with `dsp_sel`=0 returns the flags in `dsp_rdata[1:0]`, with the upper bits zero, and then clears flag bit 1.
- R7: A DSP write with `dsp_sel`=0 loads the flags from `dsp_wdata[1:0]`. Clears and sets from the same cycle are applied on top of the loaded value.
- R8: A host write to offset 3 is accepted without error and changes neither the data word nor the flags.
- R9: A host read of offset 3 to 7, or a host write of offset 2 or 4 to 7, pulses `host_err` for exactly one cycle (the cycle after the strobe). Such a read returns 0, and such a write changes no state.
- R10: When a flag is set and cleared in the same cycle, the set wins. Every read returns the value from before that cycle's update.
- R11: When the host and the DSP both write the data word in the same cycle, the host value is kept.
- R12: Each read-data output holds its value until the next read on its own side.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_rd | input | 1 | Host read strobe |
| host_wr | input | 1 | Host write strobe |
| host_addr | input | HAW (3) | Host register offset |
| host_wdata | input | DW (16) | Host write data |
| host_rdata | output | DW (16) | Host read data, registered |
| host_err | output | 1 | One-cycle pulse after an access to an unmapped host offset |
| dsp_rd | input | 1 | DSP read strobe |
| dsp_wr | input | 1 | DSP write strobe |
| dsp_sel | input | 1 | DSP port select: 1 data port, 0 flag port |
| dsp_wdata | input | DW (16) | DSP write data |
| dsp_rdata | output | DW (16) | DSP read data, registered |

## Verification
The assertions check the following on every cycle:
- each data write raises its side's flag;
- a clearing read drops the reader's flag unless a set collides with it;
- a flag read returns the flags from before the update;
- the host value wins the data word;
- unmapped host reads return zero with an error pulse;
- read data is stable when there is no read.

Some behaviours only the bench scenarios can show. These are a flag load combined with a same-cycle set, the absence of any effect from the offset-3 write, and the exact sequences of collisions. The bench reaches them by reading the state back through both ports after each step.

// File: rtl/smbx_pkg.sv
package smbx_pkg;

  localparam int FLAG_W   = 2;
  localparam int FLAG_DSP = 0;
  localparam int FLAG_HST = 1;

  // Host offsets (decode depends on these values)
  localparam int OFS_DATA_LO = 0;
  localparam int OFS_DATA_HI = 1;
  localparam int OFS_FLAGS   = 2;
  localparam int OFS_NOP     = 3;

  // Flag update order: optional direct load, then clears, then sets (set wins)
  function automatic logic [FLAG_W-1:0] flags_update(
    input logic [FLAG_W-1:0] cur,
    input logic              ld_en,
    input logic [FLAG_W-1:0] ld_val,
    input logic [FLAG_W-1:0] clr,
    input logic [FLAG_W-1:0] set
  );
    logic [FLAG_W-1:0] base;
    base = ld_en ? ld_val : cur;
    return (base & ~clr) | set;
  endfunction

endpackage

// File: rtl/smbx_host_dec.sv
module smbx_host_dec #(
  parameter int AW = 3
) (
  input  logic          rd,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  output logic          data_wr,
  output logic          data_rd,
  output logic          flag_rd,
  output logic          bad_rd,
  output logic          bad_wr
);
  import smbx_pkg::*;

  logic is_data, is_flags, is_nop;

  always_comb begin
    is_data  = (addr == AW'(OFS_DATA_LO)) || (addr == AW'(OFS_DATA_HI));
    is_flags = (addr == AW'(OFS_FLAGS));
    is_nop   = (addr == AW'(OFS_NOP));
    data_wr  = wr & is_data;
    data_rd  = rd & is_data;
    flag_rd  = rd & is_flags;
    bad_rd   = rd & ~(is_data | is_flags);
    bad_wr   = wr & ~(is_data | is_nop);
  end

endmodule

// File: rtl/smbx_dsp_dec.sv
module smbx_dsp_dec (
  input  logic rd,
  input  logic wr,
  input  logic sel,
  output logic data_wr,
  output logic data_rd,
  output logic flag_rd,
  output logic flag_ld
);

  always_comb begin
    data_wr = wr &  sel;
    data_rd = rd &  sel;
    flag_rd = rd & ~sel;
    flag_ld = wr & ~sel;
  end

endmodule

// File: rtl/smbx_regs.sv
module smbx_regs #(
  parameter int DW = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      h_data_wr,
  input  logic                      h_data_rd,
  input  logic                      h_flag_rd,
  input  logic                      h_bad_rd,
  input  logic                      h_bad_wr,
  input  logic [DW-1:0]             h_wdata,
  input  logic                      d_data_wr,
  input  logic                      d_data_rd,
  input  logic                      d_flag_rd,
  input  logic                      d_flag_ld,
  input  logic [DW-1:0]             d_wdata,
  output logic [DW-1:0]             data_q,
  output logic [smbx_pkg::FLAG_W-1:0] flags_q,
  output logic [DW-1:0]             h_rdata,
  output logic                      h_err,
  output logic [DW-1:0]             d_rdata
);
  import smbx_pkg::*;

  logic [FLAG_W-1:0] clr_vec, set_vec, flags_d;

  always_comb begin
    clr_vec           = '0;
    set_vec           = '0;
    clr_vec[FLAG_DSP] = h_flag_rd;
    clr_vec[FLAG_HST] = d_flag_rd;
    set_vec[FLAG_DSP] = d_data_wr;
    set_vec[FLAG_HST] = h_data_wr;
    flags_d = flags_update(flags_q, d_flag_ld, d_wdata[FLAG_W-1:0], clr_vec, set_vec);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_q  <= '0;
      flags_q <= '0;
      h_rdata <= '0;
      h_err   <= 1'b0;
      d_rdata <= '0;
    end else begin
      flags_q <= flags_d;
      if (h_data_wr)      data_q <= h_wdata;
      else if (d_data_wr) data_q <= d_wdata;

      if (h_data_rd)      h_rdata <= data_q;
      else if (h_flag_rd) h_rdata <= DW'(flags_q);
      else if (h_bad_rd)  h_rdata <= '0;

      if (d_data_rd)      d_rdata <= data_q;
      else if (d_flag_rd) d_rdata <= DW'(flags_q);

      h_err <= h_bad_rd | h_bad_wr;
    end
  end

endmodule

// File: rtl/smbx_top.sv
module smbx_top #(
  parameter int DW  = 16,
  parameter int HAW = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           host_rd,
  input  logic           host_wr,
  input  logic [HAW-1:0] host_addr,
  input  logic [DW-1:0]  host_wdata,
  output logic [DW-1:0]  host_rdata,
  output logic           host_err,
  input  logic           dsp_rd,
  input  logic           dsp_wr,
  input  logic           dsp_sel,
  input  logic [DW-1:0]  dsp_wdata,
  output logic [DW-1:0]  dsp_rdata
);
  import smbx_pkg::*;

  // Named internal events, also observed by the bound checker
  logic                h_data_wr, h_data_rd, h_flag_rd, h_bad_rd, h_bad_wr;
  logic                d_data_wr, d_data_rd, d_flag_rd, d_flag_ld;
  logic [DW-1:0]       data_q;
  logic [FLAG_W-1:0]   flags_q;

  smbx_host_dec #(.AW(HAW)) u_hdec (
    .rd(host_rd), .wr(host_wr), .addr(host_addr),
    .data_wr(h_data_wr), .data_rd(h_data_rd), .flag_rd(h_flag_rd),
    .bad_rd(h_bad_rd), .bad_wr(h_bad_wr)
  );

  smbx_dsp_dec u_ddec (
    .rd(dsp_rd), .wr(dsp_wr), .sel(dsp_sel),
    .data_wr(d_data_wr), .data_rd(d_data_rd),
    .flag_rd(d_flag_rd), .flag_ld(d_flag_ld)
  );

  smbx_regs #(.DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .h_data_wr(h_data_wr), .h_data_rd(h_data_rd), .h_flag_rd(h_flag_rd),
    .h_bad_rd(h_bad_rd), .h_bad_wr(h_bad_wr), .h_wdata(host_wdata),
    .d_data_wr(d_data_wr), .d_data_rd(d_data_rd), .d_flag_rd(d_flag_rd),
    .d_flag_ld(d_flag_ld), .d_wdata(dsp_wdata),
    .data_q(data_q), .flags_q(flags_q),
    .h_rdata(host_rdata), .h_err(host_err), .d_rdata(dsp_rdata)
  );

endmodule

// File: rtl/smbx_chk.sv
module smbx_chk #(
  parameter int DW = 16,
  parameter int AW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          host_rd,
  input logic [AW-1:0] host_addr,
  input logic [DW-1:0] host_wdata,
  input logic [DW-1:0] host_rdata,
  input logic          host_err,
  input logic [DW-1:0] dsp_rdata,
  input logic          dsp_rd,
  input logic [DW-1:0] dsp_wdata,
  input logic          h_data_wr,
  input logic          h_flag_rd,
  input logic          d_data_wr,
  input logic          d_flag_rd,
  input logic          d_flag_ld,
  input logic [DW-1:0] data_q,
  input logic [1:0]    flags_q
);

  assert_host_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    h_data_wr |=> flags_q[1]);

  assert_dsp_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    d_data_wr |=> flags_q[0]);

  assert_host_flag_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    h_flag_rd |=> host_rdata == DW'($past(flags_q)));

  assert_host_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (h_flag_rd && !d_data_wr) |=> !flags_q[0]);

  assert_dsp_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (d_flag_rd && !h_data_wr) |=> !flags_q[1]);

  assert_flag_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (d_flag_ld && !h_data_wr && !d_data_wr && !h_flag_rd && !d_flag_rd)
      |=> flags_q == $past(dsp_wdata[1:0]));

  assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (h_flag_rd && d_data_wr) |=> flags_q[0]);

  assert_host_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    h_data_wr |=> data_q == $past(host_wdata));

  assert_bad_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && host_addr > AW'(2)) |=> (host_err && host_rdata == '0));

  assert_host_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !host_rd |=> $stable(host_rdata));

  assert_dsp_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !dsp_rd |=> $stable(dsp_rdata));

endmodule

bind smbx_top smbx_chk #(.DW(DW), .AW(HAW)) u_chk (
  .clk(clk), .rst_n(rst_n), .host_rd(host_rd), .host_addr(host_addr),
  .host_wdata(host_wdata), .host_rdata(host_rdata), .host_err(host_err),
  .dsp_rdata(dsp_rdata), .dsp_rd(dsp_rd), .dsp_wdata(dsp_wdata),
  .h_data_wr(h_data_wr), .h_flag_rd(h_flag_rd), .d_data_wr(d_data_wr),
  .d_flag_rd(d_flag_rd), .d_flag_ld(d_flag_ld),
  .data_q(data_q), .flags_q(flags_q)
);

// File: tb/tb_smbx_top.sv
module tb_smbx_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_rd = 1'b0, host_wr = 1'b0;
  logic [2:0]  host_addr = '0;
  logic [15:0] host_wdata = '0;
  logic [15:0] host_rdata;
  logic        host_err;
  logic        dsp_rd = 1'b0, dsp_wr = 1'b0, dsp_sel = 1'b0;
  logic [15:0] dsp_wdata = '0;
  logic [15:0] dsp_rdata;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  smbx_top #(.DW(16), .HAW(3)) dut (
    .clk(clk), .rst_n(rst_n),
    .host_rd(host_rd), .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .host_err(host_err),
    .dsp_rd(dsp_rd), .dsp_wr(dsp_wr), .dsp_sel(dsp_sel),
    .dsp_wdata(dsp_wdata), .dsp_rdata(dsp_rdata)
  );

  // rq, hrd, hwr, ha, hd, drd, dwr, dsel, dd, ch, eh, ee, cd, ed
  // dsel: 1 = DSP data port, 0 = DSP flag port
  typedef struct packed {
    logic [3:0]  rq;
    logic        hrd, hwr;
    logic [2:0]  ha;
    logic [15:0] hd;
    logic        drd, dwr, dsel;
    logic [15:0] dd;
    logic        ch;
    logic [15:0] eh;
    logic        ee;
    logic        cd;
    logic [15:0] ed;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t VEC [NV] = '{
    '{4'd4 ,1,0,3'd2,16'h0000, 0,0,0,16'h0000, 1,16'h0000,0, 0,16'h0000}, // R4 flags 0 after reset
    '{4'd2 ,0,1,3'd0,16'h1234, 0,0,0,16'h0000, 0,16'h0000,0, 0,16'h0000}, // R2 host write
    '{4'd3 ,1,0,3'd1,16'h0000, 0,0,0,16'h0000, 1,16'h1234,0, 0,16'h0000}, // R3 read offset 1
    '{4'd6 ,0,0,3'd0,16'h0000, 1,0,0,16'h0000, 0,16'h0000,0, 1,16'h0002}, // R6 DSP sees bit1
    '{4'd5 ,0,0,3'd0,16'h0000, 0,1,1,16'hBEEF, 0,16'h0000,0, 0,16'h0000}, // R5 DSP write
    '{4'd4 ,1,0,3'd2,16'h0000, 0,0,0,16'h0000, 1,16'h0001,0, 0,16'h0000}, // R4 host sees bit0 only
    '{4'd3 ,1,0,3'd0,16'h0000, 0,0,0,16'h0000, 1,16'hBEEF,0, 0,16'h0000}, // R3 read offset 0
    '{4'd8 ,0,1,3'd3,16'hFFFF, 0,0,0,16'h0000, 0,16'h0000,0, 0,16'h0000}, // R8 no error
    '{4'd8 ,1,0,3'd0,16'h0000, 1,0,0,16'h0000, 1,16'hBEEF,0, 1,16'h0000}, // R8 no effect
    '{4'd7 ,0,0,3'd0,16'h0000, 0,1,0,16'h0003, 0,16'h0000,0, 0,16'h0000}, // R7 load 3
    '{4'd7 ,1,0,3'd2,16'h0000, 1,0,1,16'h0000, 1,16'h0003,0, 1,16'hBEEF}, // R7 seen, R5 read
    '{4'd6 ,0,0,3'd0,16'h0000, 1,0,0,16'h0000, 0,16'h0000,0, 1,16'h0002}, // R6 after host clear
    '{4'd9 ,1,0,3'd5,16'h0000, 0,0,0,16'h0000, 1,16'h0000,1, 0,16'h0000}, // R9 bad read
    '{4'd9 ,0,0,3'd0,16'h0000, 0,0,0,16'h0000, 1,16'h0000,0, 0,16'h0000}, // R9 pulse ends, R12
    '{4'd9 ,0,1,3'd2,16'h5555, 1,0,1,16'h0000, 0,16'h0000,1, 1,16'hBEEF}, // R9 bad write
    '{4'd9 ,1,0,3'd2,16'h0000, 0,0,0,16'h0000, 1,16'h0000,0, 0,16'h0000}, // R9 flags untouched
    '{4'd10,0,1,3'd1,16'h00AA, 1,0,0,16'h0000, 0,16'h0000,0, 1,16'h0000}, // R10 set vs clear bit1
    '{4'd10,1,0,3'd2,16'h0000, 0,1,1,16'h7777, 1,16'h0002,0, 0,16'h0000}, // R10 set vs clear bit0
    '{4'd10,1,0,3'd2,16'h0000, 0,0,0,16'h0000, 1,16'h0003,0, 0,16'h0000}, // R10 both set won
    '{4'd11,0,1,3'd0,16'h1111, 0,1,1,16'h2222, 0,16'h0000,0, 0,16'h0000}, // R11 collision
    '{4'd11,1,0,3'd2,16'h0000, 1,0,1,16'h0000, 1,16'h0003,0, 1,16'h1111}, // R11 host kept
    '{4'd7 ,0,1,3'd0,16'h4444, 0,1,0,16'h0001, 0,16'h0000,0, 0,16'h0000}, // R7 load plus set
    '{4'd7 ,1,0,3'd0,16'h0000, 1,0,0,16'h0000, 1,16'h4444,0, 1,16'h0003}, // R7 result 3
    '{4'd12,0,0,3'd0,16'h0000, 0,0,0,16'h0000, 1,16'h4444,0, 1,16'h0003}  // R12 both held
  };

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    @(negedge clk);
    host_rd = v.hrd; host_wr = v.hwr; host_addr = v.ha; host_wdata = v.hd;
    dsp_rd = v.drd; dsp_wr = v.dwr; dsp_sel = v.dsel; dsp_wdata = v.dd;
  endtask

  task automatic idle();
    @(negedge clk);
    host_rd = 0; host_wr = 0; dsp_rd = 0; dsp_wr = 0;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 host_rdata", host_rdata, 16'h0);
    check("R1 dsp_rdata", dsp_rdata, 16'h0);
    check("R1 host_err", {15'b0, host_err}, 16'h0);
    @(negedge clk) rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i]);
      @(posedge clk);
      #1;
      check($sformatf("R%0d vec%0d err", VEC[i].rq, i), {15'b0, host_err}, {15'b0, VEC[i].ee});
      if (VEC[i].ch)
        check($sformatf("R%0d vec%0d host", VEC[i].rq, i), host_rdata, VEC[i].eh);
      if (VEC[i].cd)
        check($sformatf("R%0d vec%0d dsp", VEC[i].rq, i), dsp_rdata, VEC[i].ed);
    end
    idle();

    // R9: unmapped write then immediate valid access: pulse lasts one cycle
    drive('{4'd9,0,1,3'd6,16'h9999,0,0,0,16'h0,0,16'h0,0,0,16'h0});
    drive('{4'd9,1,0,3'd0,16'h0,0,0,0,16'h0,0,16'h0,0,0,16'h0});
    @(posedge clk); #1;
    check("R9 err single cycle", {15'b0, host_err}, 16'h0);
    check("R9 data after bad write", host_rdata, 16'h4444);
    idle();

    // R1: reset in mid-run clears state
    @(negedge clk) rst_n = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    check("R1 mid host_rdata", host_rdata, 16'h0);
    check("R1 mid dsp_rdata", dsp_rdata, 16'h0);
    @(negedge clk) rst_n = 1'b1;
    drive('{4'd1,1,0,3'd0,16'h0,1,0,0,16'h0,0,16'h0,0,0,16'h0});
    @(posedge clk); #1;
    check("R1 data cleared", host_rdata, 16'h0);
    check("R1 flags cleared", dsp_rdata, 16'h0);
    idle();

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule